// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Code Loader

This block is the digital front end of a two-channel 12-bit digital-to-analog converter, written as a synchronous model. A processor with an 8-bit bus writes each channel's code in two loads. One load carries the low eight bits. The other carries the upper four bits, taken from the lowest four bus lines, so the data is right-justified. Two address lines pick the target register, and a load is qualified by active-low chip select and write strobes. The bytes collect in a holding register for each channel.

A separate active-low transfer strobe, driven low together with the write strobe, copies both holding registers into the output code registers on the same clock edge. Software can therefore stage both channels and then change them together. The strobes are sampled on the system clock, and each strobe condition acts once, on the first cycle it becomes true. An asynchronous active-low clear zeroes every register at once.

Top module: `dual_dac_loader`

## Requirements
- R1: Driving `clr_n` low zeroes both holding registers and both output codes at once, without waiting for a clock edge.
- R2: A load to address 0 (channel A) or address 2 (channel B) places `bus[7:0]` into bits 7..0 of that channel's holding register and leaves bits 11..8 unchanged.
- R3: A load to address 1 (channel A) or address 3 (channel B) places `bus[3:0]` into bits 11..8 of that channel's holding register; `bus[7:4]` has no effect and bits 7..0 are unchanged.
- R4: A holding register is loaded only in a cycle where both `cs_n` and `wr_n` are low; with `cs_n` high the bus and address have no effect.
- R5: Loads to holding registers leave `dac_a` and `dac_b` unchanged until a transfer occurs.
- R6: When `upd_n` and `wr_n` are both low, both holding registers are copied into `dac_a` and `dac_b` on the same clock edge, whatever the state of `cs_n`; the outputs show the new codes one clock after the strobe is sampled.
- R7: A load or a transfer happens once, on the first sampled cycle in which its condition becomes true; keeping the condition true for further cycles repeats nothing.
- R8: When a load and a transfer fire in the same cycle, the transfer carries the value just loaded.
- R9: Apart from clear, the outputs change only at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| upd_n | input | 1 | Transfer strobe, active low, acts together with `wr_n` |
| addr | input | 2 | Target select: 0 A low, 1 A high, 2 B low, 3 B high |
| bus | input | 8 | Data bus |
| dac_a | output | 12 | Channel A output code |
| dac_b | output | 12 | Channel B output code |

## Verification
A byte load and the transfer to the output registers can fire on the same clock edge when `cs_n`, `wr_n` and `upd_n` all fall together. The bench makes this happen both in directed cases and in random strobe mixes. It judges the result by comparing both outputs with a model in which the loaded byte is merged first and the merged code is then copied. Held strobes that only partly change, where `wr_n` and `upd_n` stay low while `cs_n` toggles, check that only the newly true condition acts.

// File: rtl/dacld_pkg.sv
package dacld_pkg;
  typedef enum logic [1:0] {
    SEL_A_LO = 2'b00,
    SEL_A_HI = 2'b01,
    SEL_B_LO = 2'b10,
    SEL_B_HI = 2'b11
  } dacld_sel_e;
endpackage

// File: rtl/dacld_strobe_edge.sv
module dacld_strobe_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [N-1:0] level,
  output logic [N-1:0] rise
);
  logic [N-1:0] level_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) level_q <= '0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/dacld_hold_reg.sv
module dacld_hold_reg #(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              load,
  input  logic              sel_hi,
  input  logic [BUS_W-1:0]  bus,
  output logic [CODE_W-1:0] q,
  output logic [CODE_W-1:0] q_next
);
  localparam int HI_W = CODE_W - BUS_W;

  always_comb begin
    q_next = q;
    if (load) begin
      if (sel_hi) q_next[CODE_W-1:BUS_W] = bus[HI_W-1:0];
      else        q_next[BUS_W-1:0]      = bus;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_next;
  end
endmodule

// File: rtl/dacld_out_reg.sv
module dacld_out_reg #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              xfer,
  input  logic [CODE_W-1:0] d,
  output logic [CODE_W-1:0] q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)    q <= '0;
    else if (xfer) q <= d;
  end
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader #(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              upd_n,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  bus,
  output logic [CODE_W-1:0] dac_a,
  output logic [CODE_W-1:0] dac_b
);
  import dacld_pkg::*;

  localparam int NCH = 2;

  logic [1:0] cond, fire;
  logic load_fire, xfer_fire;
  logic [CODE_W-1:0] hold_q    [NCH];
  logic [CODE_W-1:0] hold_next [NCH];
  logic [CODE_W-1:0] out_q     [NCH];
  logic [CODE_W-1:0] hold_a_q, hold_b_q;

  assign cond[0] = !cs_n && !wr_n;
  assign cond[1] = !upd_n && !wr_n;

  dacld_strobe_edge #(.N(2)) u_edge (
    .clk(clk), .clr_n(clr_n), .level(cond), .rise(fire)
  );

  assign load_fire = fire[0];
  assign xfer_fire = fire[1];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic ch_hit;
    assign ch_hit = load_fire && (addr[1] == ch[0]);

    dacld_hold_reg #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_hold (
      .clk(clk), .clr_n(clr_n), .load(ch_hit), .sel_hi(addr[0]),
      .bus(bus), .q(hold_q[ch]), .q_next(hold_next[ch])
    );

    dacld_out_reg #(.CODE_W(CODE_W)) u_out (
      .clk(clk), .clr_n(clr_n), .xfer(xfer_fire),
      .d(hold_next[ch]), .q(out_q[ch])
    );
  end

  assign dac_a    = out_q[0];
  assign dac_b    = out_q[1];
  assign hold_a_q = hold_q[0];
  assign hold_b_q = hold_q[1];
endmodule

// File: rtl/dual_dac_loader_chk.sv
module dual_dac_loader_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              clr_n,
  input logic              cs_n,
  input logic              wr_n,
  input logic              upd_n,
  input logic [CODE_W-1:0] dac_a,
  input logic [CODE_W-1:0] dac_b,
  input logic [CODE_W-1:0] hold_a_q,
  input logic [CODE_W-1:0] hold_b_q
);
  logic xfer_seen_q;
  logic xfer_lvl;
  assign xfer_lvl = !upd_n && !wr_n;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) xfer_seen_q <= 1'b0;
    else        xfer_seen_q <= xfer_lvl;
  end

  // R1: while clear is held, every output code reads zero
  always @(posedge clk) begin
    if (!clr_n) p_clear_zero_r1: assert (dac_a == '0 && dac_b == '0);
  end

  p_cs_ignore_r4: assert property (@(posedge clk) disable iff (!clr_n)
    cs_n |=> ($stable(hold_a_q) && $stable(hold_b_q)));

  p_hold_out_r5: assert property (@(posedge clk) disable iff (!clr_n)
    !xfer_lvl |=> ($stable(dac_a) && $stable(dac_b)));

  p_copy_both_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (xfer_lvl && !xfer_seen_q && cs_n)
      |=> (dac_a == $past(hold_a_q) && dac_b == $past(hold_b_q)));

  p_once_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (xfer_lvl && xfer_seen_q) |=> ($stable(dac_a) && $stable(dac_b)));
endmodule

bind dual_dac_loader dual_dac_loader_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n),
  .dac_a(dac_a), .dac_b(dac_b), .hold_a_q(hold_a_q), .hold_b_q(hold_b_q)
);

// File: tb/dual_dac_loader_bench.sv
module dual_dac_loader_bench;
  logic clk = 1'b0;
  logic clr_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, upd_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] bus = '0;
  logic [11:0] dac_a, dac_b;

  int n_cmp = 0, n_bad = 0;
  logic [11:0] m_hold [2];
  logic [11:0] m_out  [2];

  always #10 clk = ~clk;

  dual_dac_loader u_dual_dac_loader (
    .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n),
    .addr(addr), .bus(bus), .dac_a(dac_a), .dac_b(dac_b)
  );

  function automatic logic [11:0] merge(logic [11:0] old, logic [1:0] a, logic [7:0] d);
    logic [11:0] r = old;
    if (a[0]) r[11:8] = d[3:0];
    else      r[7:0]  = d;
    return r;
  endfunction

  task automatic check(string req, logic [11:0] ea, logic [11:0] eb);
    n_cmp++;
    if (dac_a !== ea || dac_b !== eb) begin
      n_bad++;
      $display("FAIL %s: dac_a=%h dac_b=%h expected %h %h", req, dac_a, dac_b, ea, eb);
    end
  endtask

  // one strobe pulse, then idle; model updated from requirements
  task automatic op(logic c, logic w, logic u, logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cs_n = c; wr_n = w; upd_n = u; addr = a; bus = d;
    if (!c && !w) m_hold[a[1]] = merge(m_hold[a[1]], a, d);   // R2 R3 R4
    if (!u && !w) begin m_out[0] = m_hold[0]; m_out[1] = m_hold[1]; end // R6 R8
    @(negedge clk);
    cs_n = 1; wr_n = 1; upd_n = 1;
    @(negedge clk);
  endtask

  task automatic model_clear();
    m_hold[0] = '0; m_hold[1] = '0; m_out[0] = '0; m_out[1] = '0;
  endtask

  initial begin : watchdog
    #3000000;
    n_bad++; n_cmp++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_clear();
    #35;
    check("R1 reset", 12'h000, 12'h000);
    clr_n = 1'b1;

    // R2/R3/R5: staged loads do not reach outputs
    op(0, 0, 1, 2'd0, 8'hA5);
    op(0, 0, 1, 2'd1, 8'hF3);   // R3 upper bus bits ignored
    op(0, 0, 1, 2'd2, 8'h5C);
    op(0, 0, 1, 2'd3, 8'h79);
    check("R5 staged", 12'h000, 12'h000);
    // R6: transfer both, cs high
    op(1, 0, 0, 2'd0, 8'h00);
    check("R6 R2 R3 transfer", 12'h3A5, 12'h95C);

    // R4: cs high ignored
    op(1, 0, 1, 2'd0, 8'hFF);
    op(1, 0, 0, 2'd0, 8'h00);
    check("R4 cs high ignored", 12'h3A5, 12'h95C);

    // R8: load and transfer together
    op(0, 0, 0, 2'd3, 8'hE1);
    check("R8 same-cycle", 12'h3A5, 12'h15C);

    // R9: output changes exactly one edge after the strobe
    @(negedge clk);
    wr_n = 0; cs_n = 0; upd_n = 0; addr = 2'd0; bus = 8'h11;
    check("R9 before edge", 12'h3A5, 12'h15C);
    @(negedge clk);
    check("R9 after edge", 12'h311, 12'h15C);
    // R7: keep wr/upd low, drive new bus, then re-trigger load via cs
    bus = 8'h22; @(negedge clk);
    cs_n = 1; @(negedge clk);
    cs_n = 0; bus = 8'h33; @(negedge clk);
    check("R7 held strobes act once", 12'h311, 12'h15C);
    cs_n = 1; wr_n = 1; upd_n = 1; @(negedge clk);
    m_hold[0] = 12'h333; m_hold[1] = 12'h15C; m_out[0] = 12'h311; m_out[1] = 12'h15C;
    op(1, 0, 0, 2'd0, 8'h00);
    check("R7 second load landed", 12'h333, 12'h15C);

    // R1: async clear mid-cycle
    @(negedge clk); #3;
    clr_n = 0; #1;
    check("R1 async clear", 12'h000, 12'h000);
    @(negedge clk); clr_n = 1; model_clear();
    op(1, 0, 0, 2'd0, 8'h00);
    check("R1 hold regs cleared", 12'h000, 12'h000);

    // random mix, R2..R8
    for (int i = 0; i < 400; i++) begin
      logic c, u;
      logic [1:0] a;
      logic [7:0] d;
      c = ($urandom % 4) == 0;
      u = ($urandom % 3) != 0;
      a = 2'($urandom);
      d = 8'($urandom);
      op(c, 0, u, a, d);
      check("R2 R3 R4 R5 R6 R8 random", m_out[0], m_out[1]);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule